// File: doc/BRIEF.md
# Two-Way Processor Mailbox

This block lets two processors, called side A and side B, exchange short messages. There is one channel for each direction. A channel holds a command word, a data word and a pending flag. The sender loads the data word first and the command word second. The command write is what posts the message. It sets the flag, and the flag drives a level interrupt toward the peer. The receiver may read the data word as often as it likes. Reading the command word acknowledges the message, which clears the flag and drops the interrupt.

Each side has its own synchronous register port with a select, a write enable, a 2-bit address and a 16-bit write bus. Read data is combinational and valid in the cycle the read is issued. The same address decodes to the outbound channel on a write and to the inbound channel on a read. A status word shows the pending flags of both channels. A sticky overflow bit records that the sender posted a new message before the old one was taken.

Top module: `mbox_duplex`

## Requirements
- R1: After reset all command, data, pending and overflow state is zero, both interrupts are low and read data is zero.
- R2: A write to address 0 stores the word as the command of the writer's outbound channel and sets that channel's pending flag at that edge. The peer's interrupt is high from that edge on.
- R3: A write to address 1 stores the word as the outbound data and changes neither the pending flag nor the interrupt. A read of address 1 returns the inbound data and has no side effect.
- R4: A read of address 0 returns the inbound command and clears the inbound pending flag at the next edge. The reader's interrupt is then low.
- R5: A read of address 2 returns status: bit 0 is the inbound pending flag, bit 1 is the outbound pending flag, bit 2 is the outbound overflow bit, and the other bits are zero.
- R6: A command write while the outbound flag is set, with no acknowledge in the same cycle, overwrites the command, keeps the flag set and sets the sticky overflow bit.
- R7: A write to address 2 with bit 2 set clears the writer's outbound overflow bit. A write to address 2 with bit 2 clear leaves it unchanged.
- R8: If a command write and the peer's acknowledge reach one channel in the same cycle, the read returns the old command and the flag stays set with the new command. Overflow is not set.
- R9: The two channels are independent, and both may post or acknowledge in the same cycle.
- R10: Each side's interrupt equals the pending flag of its inbound channel on every cycle.
- R11: Read data is zero when the port is not selected or is writing. Address 3 reads as zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_sel_i | input | 1 | Side A access select |
| a_we_i | input | 1 | Side A write enable |
| a_addr_i | input | 2 | Side A register address |
| a_wdata_i | input | 16 | Side A write data |
| a_rdata_o | output | 16 | Side A read data |
| a_irq_o | output | 1 | Interrupt to side A, message from B pending |
| b_sel_i | input | 1 | Side B access select |
| b_we_i | input | 1 | Side B write enable |
| b_addr_i | input | 2 | Side B register address |
| b_wdata_i | input | 16 | Side B write data |
| b_rdata_o | output | 16 | Side B read data |
| b_irq_o | output | 1 | Interrupt to side B, message from A pending |

## Verification
The bound checker watches every cycle for the following:
- a command write is always followed by a raised interrupt;
- the interrupt never rises without a command write;
- a data write leaves the interrupt alone;
- an acknowledge without a same-cycle post drops it;
- overflow is set by a post onto a pending channel and stays set until cleared;
- an idle port reads zero.

Only the bench's scenarios can show that the words read back are the ones that were written. The same holds for the status layout, the write-1-to-clear rule with its ignored zero write, and the same-cycle post-and-acknowledge case returning the old command. Those checks are made against a reference model driven by mixed random and directed traffic on both sides at once.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  localparam int unsigned NUM_SIDES = 2;
  localparam int unsigned ADDR_W    = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CMD  = 2'd0,
    REG_DATA = 2'd1,
    REG_STAT = 2'd2,
    REG_RSVD = 2'd3
  } reg_sel_e;

  localparam int unsigned STAT_IN_PEND  = 0;
  localparam int unsigned STAT_OUT_PEND = 1;
  localparam int unsigned STAT_OUT_OVF  = 2;
endpackage

// File: rtl/mbox_channel.sv
`timescale 1ns/1ps
module mbox_channel #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              post_i,
  input  logic [WORD_W-1:0] cmd_i,
  input  logic              data_we_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              ack_i,
  input  logic              ovf_clr_i,
  output logic [WORD_W-1:0] cmd_o,
  output logic [WORD_W-1:0] data_o,
  output logic              pend_o,
  output logic              ovf_o
);
  logic [WORD_W-1:0] cmd_q, data_q;
  logic              pend_q, pend_d, ovf_q, ovf_d, ovf_set;

  // post wins over a same-cycle ack; overflow only when the old message is lost
  always_comb begin
    ovf_set = post_i & pend_q & ~ack_i;
    pend_d  = post_i | (pend_q & ~ack_i);
    ovf_d   = ovf_set | (ovf_q & ~ovf_clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      data_q <= '0;
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (post_i)    cmd_q  <= cmd_i;
      if (data_we_i) data_q <= data_i;
      pend_q <= pend_d;
      ovf_q  <= ovf_d;
    end
  end

  assign cmd_o  = cmd_q;
  assign data_o = data_q;
  assign pend_o = pend_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/mbox_port.sv
`timescale 1ns/1ps
module mbox_port
  import mbox_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              post_o,
  output logic              data_we_o,
  output logic              ack_o,
  output logic              ovf_clr_o,
  input  logic [WORD_W-1:0] in_cmd_i,
  input  logic [WORD_W-1:0] in_data_i,
  input  logic              in_pend_i,
  input  logic              out_pend_i,
  input  logic              out_ovf_i
);
  reg_sel_e reg_sel;
  logic     wr, rd;

  assign reg_sel = reg_sel_e'(addr_i);
  assign wr      = sel_i & we_i;
  assign rd      = sel_i & ~we_i;

  assign post_o    = wr & (reg_sel == REG_CMD);
  assign data_we_o = wr & (reg_sel == REG_DATA);
  assign ovf_clr_o = wr & (reg_sel == REG_STAT) & wdata_i[STAT_OUT_OVF];
  assign ack_o     = rd & (reg_sel == REG_CMD);

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (reg_sel)
        REG_CMD:  rdata_o = in_cmd_i;
        REG_DATA: rdata_o = in_data_i;
        REG_STAT: begin
          rdata_o[STAT_IN_PEND]  = in_pend_i;
          rdata_o[STAT_OUT_PEND] = out_pend_i;
          rdata_o[STAT_OUT_OVF]  = out_ovf_i;
        end
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/mbox_duplex.sv
`timescale 1ns/1ps
module mbox_duplex
  import mbox_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_sel_i,
  input  logic              a_we_i,
  input  logic [1:0]        a_addr_i,
  input  logic [WORD_W-1:0] a_wdata_i,
  output logic [WORD_W-1:0] a_rdata_o,
  output logic              a_irq_o,
  input  logic              b_sel_i,
  input  logic              b_we_i,
  input  logic [1:0]        b_addr_i,
  input  logic [WORD_W-1:0] b_wdata_i,
  output logic [WORD_W-1:0] b_rdata_o,
  output logic              b_irq_o
);
  // channel s carries messages sent by side s; side 0 = A, side 1 = B
  logic [NUM_SIDES-1:0]             sel_w, we_w;
  logic [NUM_SIDES-1:0][ADDR_W-1:0] addr_w;
  logic [NUM_SIDES-1:0][WORD_W-1:0] wdata_w, rdata_w, cmd_w, data_w;
  logic [NUM_SIDES-1:0]             post_w, dwe_w, ack_w, clr_w, pend_w, ovf_w;

  assign sel_w   = {b_sel_i, a_sel_i};
  assign we_w    = {b_we_i, a_we_i};
  assign addr_w  = {b_addr_i, a_addr_i};
  assign wdata_w = {b_wdata_i, a_wdata_i};

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    localparam int unsigned PEER = NUM_SIDES - 1 - s;

    mbox_channel #(.WORD_W(WORD_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .post_i    (post_w[s]),
      .cmd_i     (wdata_w[s]),
      .data_we_i (dwe_w[s]),
      .data_i    (wdata_w[s]),
      .ack_i     (ack_w[PEER]),
      .ovf_clr_i (clr_w[s]),
      .cmd_o     (cmd_w[s]),
      .data_o    (data_w[s]),
      .pend_o    (pend_w[s]),
      .ovf_o     (ovf_w[s])
    );

    mbox_port #(.WORD_W(WORD_W)) u_port (
      .sel_i      (sel_w[s]),
      .we_i       (we_w[s]),
      .addr_i     (addr_w[s]),
      .wdata_i    (wdata_w[s]),
      .rdata_o    (rdata_w[s]),
      .post_o     (post_w[s]),
      .data_we_o  (dwe_w[s]),
      .ack_o      (ack_w[s]),
      .ovf_clr_o  (clr_w[s]),
      .in_cmd_i   (cmd_w[PEER]),
      .in_data_i  (data_w[PEER]),
      .in_pend_i  (pend_w[PEER]),
      .out_pend_i (pend_w[s]),
      .out_ovf_i  (ovf_w[s])
    );
  end

  assign a_rdata_o = rdata_w[0];
  assign b_rdata_o = rdata_w[1];
  assign a_irq_o   = pend_w[1];
  assign b_irq_o   = pend_w[0];
endmodule

// File: rtl/mbox_duplex_chk.sv
`timescale 1ns/1ps
module mbox_duplex_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              a_sel_i,
  input logic              a_we_i,
  input logic [1:0]        a_addr_i,
  input logic [WORD_W-1:0] a_wdata_i,
  input logic [WORD_W-1:0] a_rdata_o,
  input logic              a_irq_o,
  input logic              b_sel_i,
  input logic              b_we_i,
  input logic [1:0]        b_addr_i,
  input logic              b_irq_o,
  input logic [1:0]        ovf_w
);
  logic a_post, b_post, a_ack, b_ack, a_dwr, a_clr;
  assign a_post = a_sel_i & a_we_i & (a_addr_i == 2'd0);
  assign b_post = b_sel_i & b_we_i & (b_addr_i == 2'd0);
  assign a_ack  = a_sel_i & ~a_we_i & (a_addr_i == 2'd0);
  assign b_ack  = b_sel_i & ~b_we_i & (b_addr_i == 2'd0);
  assign a_dwr  = a_sel_i & a_we_i & (a_addr_i == 2'd1);
  assign a_clr  = a_sel_i & a_we_i & (a_addr_i == 2'd2) & a_wdata_i[2];

  assert_post_raise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_post |=> b_irq_o);
  assert_rise_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(b_irq_o) |-> $past(a_post));
  assert_data_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_dwr && !b_ack) |=> $stable(b_irq_o));
  assert_ack_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_ack && !a_post) |=> !b_irq_o);
  assert_ovf_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_post && b_irq_o && !b_ack) |=> ovf_w[0]);
  assert_ovf_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_w[0] && !a_clr) |=> ovf_w[0]);
  assert_same_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_post && b_ack) |=> (b_irq_o && $stable(ovf_w[0])));
  assert_reverse_post_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_post |=> a_irq_o);
  assert_reverse_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_ack && !b_post) |=> !a_irq_o);
  assert_idle_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_sel_i |-> (a_rdata_o == '0));
endmodule

bind mbox_duplex mbox_duplex_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/sim_mbox_duplex.sv
`timescale 1ns/1ps
module sim_mbox_duplex;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        a_sel_i = 0, a_we_i = 0, b_sel_i = 0, b_we_i = 0;
  logic [1:0]  a_addr_i = 0, b_addr_i = 0;
  logic [15:0] a_wdata_i = 0, b_wdata_i = 0;
  logic [15:0] a_rdata_o, b_rdata_o;
  logic        a_irq_o, b_irq_o;

  int unsigned n_chk = 0, n_err = 0;
  bit          finished = 0;
  logic [15:0] la_rd, lb_rd;

  logic [15:0] m_cmd [2];
  logic [15:0] m_data[2];
  bit          m_pend[2];
  bit          m_ovf [2];

  always #10 clk_i = ~clk_i;

  mbox_duplex u0 (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_rd(input int s, input bit sel, input bit we,
                                         input logic [1:0] addr);
    int p = 1 - s;
    logic [15:0] r = '0;
    if (sel && !we) begin
      case (addr)
        2'd0: r = m_cmd[p];
        2'd1: r = m_data[p];
        2'd2: r = {13'd0, m_ovf[s], m_pend[s], m_pend[p]};
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [1:0] addr);
    case (addr)
      2'd0: return "R4";
      2'd1: return "R3";
      2'd2: return "R5";
      default: return "R11";
    endcase
  endfunction

  // one clock: drive at negedge, sample reads, update model at posedge
  task automatic step(input bit as, input bit aw, input logic [1:0] aa, input logic [15:0] ad,
                      input bit bs, input bit bw, input logic [1:0] ba, input logic [15:0] bd);
    bit          sel[2], we[2], post[2], dwe[2], ack[2], clr[2];
    logic [1:0]  adr[2];
    logic [15:0] wd[2];
    sel = '{as, bs}; we = '{aw, bw}; adr = '{aa, ba}; wd = '{ad, bd};
    a_sel_i = as; a_we_i = aw; a_addr_i = aa; a_wdata_i = ad;
    b_sel_i = bs; b_we_i = bw; b_addr_i = ba; b_wdata_i = bd;
    #1;
    la_rd = a_rdata_o; lb_rd = b_rdata_o;
    chk(tag_of(aa), a_rdata_o, exp_rd(0, as, aw, aa));
    chk(tag_of(ba), b_rdata_o, exp_rd(1, bs, bw, ba));
    chk("R10", {15'd0, a_irq_o}, {15'd0, m_pend[1]});
    chk("R10", {15'd0, b_irq_o}, {15'd0, m_pend[0]});
    @(posedge clk_i);
    for (int s = 0; s < 2; s++) begin
      post[s] = sel[s] && we[s] && adr[s] == 2'd0;
      dwe[s]  = sel[s] && we[s] && adr[s] == 2'd1;
      clr[s]  = sel[s] && we[s] && adr[s] == 2'd2 && wd[s][2];
      ack[s]  = sel[1-s] && !we[1-s] && adr[1-s] == 2'd0;
    end
    for (int s = 0; s < 2; s++) begin
      if (post[s]) m_cmd[s] = wd[s];
      if (dwe[s])  m_data[s] = wd[s];
      if (post[s] && m_pend[s] && !ack[s]) m_ovf[s] = 1;
      else if (clr[s])                     m_ovf[s] = 0;
      m_pend[s] = post[s] ? 1'b1 : (ack[s] ? 1'b0 : m_pend[s]);
    end
    @(negedge clk_i);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      m_cmd[s] = 0; m_data[s] = 0; m_pend[s] = 0; m_ovf[s] = 0;
    end
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk_i);
    chk("R1", {14'd0, a_irq_o, b_irq_o}, 16'd0);
    chk("R1", a_rdata_o, 16'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step(1, 0, 2, 0, 1, 0, 0, 0);
    chk("R1", la_rd, 16'h0000);
    chk("R1", lb_rd, 16'h0000);
    // data write alone
    step(1, 1, 1, 16'hbeef, 0, 0, 0, 0);
    chk("R3", {15'd0, b_irq_o}, 16'd0);
    // post
    step(1, 1, 0, 16'h0101, 0, 0, 0, 0);
    chk("R2", {15'd0, b_irq_o}, 16'd1);
    step(0, 0, 0, 0, 1, 0, 1, 0);
    chk("R3", lb_rd, 16'hbeef);
    chk("R3", {15'd0, b_irq_o}, 16'd1);
    step(1, 0, 2, 0, 1, 0, 2, 0);
    chk("R5", la_rd, 16'h0002);
    chk("R5", lb_rd, 16'h0001);
    // overflow
    step(1, 1, 0, 16'h0202, 0, 0, 0, 0);
    step(1, 0, 2, 0, 0, 0, 0, 0);
    chk("R6", la_rd, 16'h0006);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R6", lb_rd, 16'h0202);
    chk("R4", {15'd0, b_irq_o}, 16'd0);
    // clear rules
    step(1, 1, 2, 16'hfffb, 0, 0, 0, 0);
    step(1, 0, 2, 0, 0, 0, 0, 0);
    chk("R7", la_rd, 16'h0004);
    step(1, 1, 2, 16'h0004, 0, 0, 0, 0);
    step(1, 0, 2, 0, 0, 0, 0, 0);
    chk("R7", la_rd, 16'h0000);
    // same-cycle post and ack
    step(1, 1, 0, 16'h0303, 0, 0, 0, 0);
    step(1, 1, 0, 16'h0404, 1, 0, 0, 0);
    chk("R8", lb_rd, 16'h0303);
    chk("R8", {15'd0, b_irq_o}, 16'd1);
    step(1, 0, 2, 0, 1, 0, 0, 0);
    chk("R8", la_rd, 16'h0002);
    chk("R8", lb_rd, 16'h0404);
    // both directions at once
    step(1, 1, 0, 16'h0606, 1, 1, 0, 16'h0707);
    chk("R9", {14'd0, a_irq_o, b_irq_o}, 16'd3);
    step(1, 0, 0, 0, 1, 0, 0, 0);
    chk("R9", la_rd, 16'h0707);
    chk("R9", lb_rd, 16'h0606);
    chk("R9", {14'd0, a_irq_o, b_irq_o}, 16'd0);
    // reserved address
    step(1, 1, 3, 16'hffff, 1, 1, 3, 16'hffff);
    step(1, 0, 3, 0, 1, 0, 2, 0);
    chk("R11", la_rd, 16'h0000);
    chk("R11", lb_rd, 16'h0000);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] ad, bd;
      ad = 16'($urandom); bd = 16'($urandom);
      step(($urandom % 10) < 7, $urandom % 2, 2'($urandom), ad,
           ($urandom % 10) < 7, $urandom % 2, 2'($urandom), bd);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule